// File: doc/BRIEF.md
# Round-Robin Tick Scheduler with Tone Generator

The block divides a fast system clock into a periodic base tick and hands each base tick to one task slot of a short repeating frame. Every slot gets its own enable strobe that fires at a fraction of the base tick rate. Slot 0 clocks an internal square-wave tone generator. Slot 1 is the enable for an external measurement block. Slots 2 and 3 carry no work. Slot 4 ends the frame, so the frame is five base ticks long.

The tone generator is a count-down-then-reload toggler. Each time its slot is served, it either decrements its counter or, when it finds the counter at zero, reloads the counter from a programmable 16-bit reload register and inverts the tone pin. One half-period of the tone is therefore (reload + 1) frames. A write port updates the reload register. A new value only takes effect at the next reload, so a tone half-period that is already under way keeps its length.

Top module: `tick_slot_sched`

## Requirements
- R1: A base tick occurs once every TICK_DIV (default 125) clocks. The first one comes TICK_DIV clocks after reset is released, and two successive slot enables are always exactly TICK_DIV clocks apart.
- R2: `slotIdx` holds the slot most recently dispatched and changes only on a base tick. Dispatched slots follow the order 0, 1, 2, 3, 4 and then repeat.
- R3: At most one bit of `slotEn` is high in any clock. A bit is high for exactly one clock, in the clock where the base tick occurs, and no bit is high between ticks.
- R4: Bit k of `slotEn` belongs to slot k. Bit 0 is the tone service and bit 1 is the measurement enable. Bits 2 and 3 do nothing inside the block, and bit 4 is the frame-terminating slot.
- R5: When the tone slot is served and the tone counter is nonzero, the counter decreases by one and `toneOut` keeps its value. Outside tone service, neither the counter nor `toneOut` changes.
- R6: When the tone slot is served and the tone counter is zero, the counter takes the reload register value and `toneOut` inverts. Each tone half-period is therefore (reload + 1) × 5 × TICK_DIV clocks.
- R7: After a synchronous reset, `toneOut` is 0, no `slotEn` bit is high, `slotIdx` reads 4, the tone counter is 0 and the reload register is 9. The first tone service then drives `toneOut` high, and the following half-period lasts 6250 clocks.
- R8: A write (`reloadWe` high for one clock with `reloadVal`) updates the reload register but does not alter the count under way. The half-period in progress keeps its old length, and the new value governs only the half-periods that start after the next reload.
- R9: The tick after the terminating slot 4 dispatches slot 0. Any slot index at or above 4 is handled like the terminating slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reloadWe | input | 1 | Write strobe for the reload register |
| reloadVal | input | 16 | New tone half-period reload value |
| toneOut | output | 1 | Square-wave tone pin |
| slotEn | output | 5 | One-clock enable per slot; bit 1 is the measurement enable |
| slotIdx | output | 4 | Index of the slot dispatched most recently |

## Verification
The hardest case to reach from the ports is a reload write that arrives while a half-period is partway through its count. Here the old length must still be observed, and only the half-period after the next reload may change. The stimulus waits for a tone edge, lets about a thousand clocks pass, and writes a new reload value. It then measures the length of the current half-period and of the next one, first for a larger-to-smaller change and then for a change to zero. A burst of writes on every clock follows. Some of those writes land in the same clock as a tone reload, and the bench's clock-by-clock model checks that the old register value is the one loaded.

// File: rtl/tick_sched_pkg.sv
package tick_sched_pkg;
  // strobes passed from the sequencer to the tone datapath
  typedef struct packed {
    logic tick;     // base tick of this clock
    logic toneSvc;  // tone slot served in this clock
  } slot_strobe_t;
endpackage

// File: rtl/tick_sched_ctrl.sv
module tick_sched_ctrl
  import tick_sched_pkg::*;
#(
  parameter int TICK_DIV  = 125,
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W    = 4,
  parameter int TONE_SLOT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [NUM_SLOTS-1:0] slotEn,
  output logic [SLOT_W-1:0]    slotIdx,
  output slot_strobe_t         strb
);
  localparam int PRE_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TERM_SLOT = NUM_SLOTS - 1;

  logic [PRE_W-1:0]  preCnt;
  logic              tick;
  logic [SLOT_W-1:0] nextSlot;

  // base tick prescaler
  assign tick = (preCnt == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // terminating slot, or anything beyond it, wraps back to slot 0
  assign nextSlot = (slotIdx >= SLOT_W'(TERM_SLOT)) ? '0 : slotIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       slotIdx <= SLOT_W'(TERM_SLOT);
    else if (tick) slotIdx <= nextSlot;
  end

  // one dispatch strobe per slot
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slotEn[k] = tick && (nextSlot == SLOT_W'(k));
  end

  assign strb.tick    = tick;
  assign strb.toneSvc = slotEn[TONE_SLOT];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick) else $error("tick lasted more than one clock"); // R1

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $countones(slotEn) <= 1) else $error("several slot enables"); // R3

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(slotIdx)) else $error("slot index moved between ticks"); // R2

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && slotIdx < SLOT_W'(TERM_SLOT)) |=> slotIdx == $past(slotIdx) + 1'b1)
    else $error("slot index did not advance"); // R2

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && slotIdx >= SLOT_W'(TERM_SLOT)) |=> slotIdx == '0)
    else $error("slot index did not wrap"); // R9
endmodule

// File: rtl/tick_sched_tone.sv
module tick_sched_tone
  import tick_sched_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RELOAD_INIT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  slot_strobe_t     strb,
  input  logic             reloadWe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             toneOut
);
  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] toneCnt;
  logic             cntZero;

  assign cntZero = (toneCnt == '0);

  // reload register; read only at a reload event
  always_ff @(posedge clk) begin
    if (rst)           reloadReg <= CNT_W'(RELOAD_INIT);
    else if (reloadWe) reloadReg <= reloadVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toneCnt <= '0;
      toneOut <= 1'b0;
    end else if (strb.toneSvc) begin
      if (cntZero) begin
        toneCnt <= reloadReg;
        toneOut <= ~toneOut;
      end else begin
        toneCnt <= toneCnt - 1'b1;
      end
    end
  end

  AST_SVC_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    strb.toneSvc |-> strb.tick) else $error("tone served off tick"); // R3

  AST_TONE_DEC: assert property (@(posedge clk) disable iff (rst)
    (strb.toneSvc && !cntZero) |=> (toneCnt == $past(toneCnt) - 1'b1) && $stable(toneOut))
    else $error("tone counter did not decrement"); // R5

  AST_TONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strb.toneSvc |=> $stable(toneCnt) && $stable(toneOut))
    else $error("tone state changed without service"); // R5

  AST_TONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (strb.toneSvc && cntZero) |=> (toneOut != $past(toneOut)) && (toneCnt == $past(reloadReg)))
    else $error("tone did not reload and flip"); // R6
endmodule

// File: rtl/tick_slot_sched.sv
module tick_slot_sched
  import tick_sched_pkg::*;
#(
  parameter int TICK_DIV    = 125,
  parameter int NUM_SLOTS   = 5,
  parameter int SLOT_W      = 4,
  parameter int TONE_SLOT   = 0,
  parameter int CNT_W       = 16,
  parameter int RELOAD_INIT = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reloadWe,
  input  logic [CNT_W-1:0]     reloadVal,
  output logic                 toneOut,
  output logic [NUM_SLOTS-1:0] slotEn,
  output logic [SLOT_W-1:0]    slotIdx
);
  slot_strobe_t strb;

  tick_sched_ctrl #(
    .TICK_DIV (TICK_DIV),
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .TONE_SLOT(TONE_SLOT)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .slotEn (slotEn),
    .slotIdx(slotIdx),
    .strb   (strb)
  );

  tick_sched_tone #(
    .CNT_W      (CNT_W),
    .RELOAD_INIT(RELOAD_INIT)
  ) u_tone (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .reloadWe (reloadWe),
    .reloadVal(reloadVal),
    .toneOut  (toneOut)
  );
endmodule

// File: tb/tick_slot_sched_bench.sv
module tick_slot_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV  = 125;
  localparam int NSLOT = 5;
  localparam int FRAME = TDIV * NSLOT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reloadWe = 1'b0;
  logic [15:0] reloadVal = '0;
  logic        toneOut;
  logic [4:0]  slotEn;
  logic [3:0]  slotIdx;

  int nChecks = 0;
  int nFail = 0;

  tick_slot_sched u_tick_slot_sched (
    .clk(clk), .rst(rst), .reloadWe(reloadWe), .reloadVal(reloadVal),
    .toneOut(toneOut), .slotEn(slotEn), .slotIdx(slotIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // behavioural reference model, advanced once per clock at the falling edge
  bit     mValid = 0;
  int     mPre, mSlot, mCnt, mReload;
  bit     mTone;
  longint cyc = 0;
  longint lastEnCyc = -1;

  always @(negedge clk) begin
    bit     isTick;
    int     nxt;
    logic [4:0] expEn;
    cyc++;
    isTick = (mPre == TDIV - 1);
    nxt    = (mSlot + 1) % NSLOT;
    expEn  = isTick ? 5'(1 << nxt) : 5'b0;
    if (mValid) begin
      chk(slotIdx == 4'(mSlot), "R2 slot index", slotIdx, mSlot);
      chk(slotEn == expEn, "R3/R4 slot enables", slotEn, expEn);
      chk(toneOut == mTone, "R5/R6 tone pin", toneOut, mTone);
      if (slotEn != 0 && !rst) begin
        if (lastEnCyc >= 0)
          chk(cyc - lastEnCyc == TDIV, "R1 enable spacing", cyc - lastEnCyc, TDIV);
        if (slotEn[0] && lastEnCyc >= 0)
          chk(slotIdx == 4'd4, "R9 slot 0 follows slot 4", slotIdx, 4);
        lastEnCyc = cyc;
      end
    end
    if (rst) begin
      mValid = 1; mPre = 0; mSlot = 4; mCnt = 0; mReload = 9; mTone = 0;
      lastEnCyc = -1;
    end else if (mValid) begin
      if (isTick) begin
        mPre = 0;
        mSlot = nxt;
        if (nxt == 0) begin
          if (mCnt != 0) mCnt--;
          else begin mCnt = mReload; mTone = !mTone; end
        end
      end else mPre++;
      if (reloadWe) mReload = int'(reloadVal);
    end
  end

  task automatic wrReload(input logic [15:0] v);
    @(posedge clk); #2; reloadWe = 1'b1; reloadVal = v;
    @(posedge clk); #2; reloadWe = 1'b0;
  endtask

  task automatic waitToggle(output longint t);
    logic prev;
    prev = toneOut;
    do @(negedge clk); while (toneOut == prev);
    t = $time / CLK_PERIOD;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    longint tA, tB, tC, tD, tE, tF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7 reset state at the ports
    chk(toneOut == 1'b0, "R7 tone low in reset", toneOut, 0);
    chk(slotEn == 5'b0, "R7 no enables in reset", slotEn, 0);
    chk(slotIdx == 4'd4, "R7 index reads 4 in reset", slotIdx, 4);
    @(posedge clk); #2; rst = 1'b0;

    waitToggle(tA);
    chk(toneOut == 1'b1, "R7 first service drives tone high", toneOut, 1);
    waitToggle(tB);
    chk(tB - tA == 10 * FRAME, "R7 default reload half-period", tB - tA, 10 * FRAME);

    repeat (1000) @(posedge clk);
    wrReload(16'd2);
    waitToggle(tC);
    chk(tC - tB == 10 * FRAME, "R8 running count unaffected", tC - tB, 10 * FRAME);
    waitToggle(tD);
    chk(tD - tC == 3 * FRAME, "R6 new reload after reload event", tD - tC, 3 * FRAME);

    repeat (100) @(posedge clk);
    wrReload(16'd0);
    waitToggle(tE);
    chk(tE - tD == 3 * FRAME, "R8 running count unaffected", tE - tD, 3 * FRAME);
    waitToggle(tF);
    chk(tF - tE == FRAME, "R6 zero reload toggles every frame", tF - tE, FRAME);

    // writes on every clock, some coinciding with reload events
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2; reloadWe = 1'b1; reloadVal = 16'(i % 4);
    end
    @(posedge clk); #2; reloadWe = 1'b0;
    repeat (3000) @(posedge clk);

    // reset in mid run
    #2; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(toneOut == 1'b0, "R7 tone low after reset", toneOut, 0);
    chk(slotIdx == 4'd4, "R7 index after reset", slotIdx, 4);
    @(posedge clk); #2; rst = 1'b0;
    repeat (3000) @(posedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule